// File: doc/BRIEF.md
# Sub-Thread Speculative Conflict Tracker

This block holds the speculative access tags that a shared second-level cache keeps for a small set of speculative threads. Each thread is divided into ordered sub-threads, and each sub-thread marks a checkpoint. For every tracked line the block keeps one load bit and one store bit per (thread, sub-thread) context. Threads are ordered by ID: a lower ID is logically earlier.

Conflicts are found eagerly, in the cycle the access arrives. When a thread stores to a line that a logically later thread has speculatively read, the block reports which later thread was hurt and the earliest sub-thread of that thread that read the line. Only that sub-thread and the ones after it then need to restart. Control inputs carry the thread lifecycle. A checkpoint moves a thread on to its next sub-thread. A rollback clears the violated sub-thread and every later one. A commit clears all of the thread's tags. The block also flags a store that would need its own copy of the line, because another thread already holds a speculative version of it. Data arrays, replacement and the first-level cache's single speculative-modified bit are handled elsewhere.

Top module: `spec_viol_tracker`

## Requirements
- R1: After reset, viol_valid and repl_hit are 0, no tag bit is set, and every thread's current sub-thread index is 0.
- R2: A store from thread T to line L while a thread U > T has a load bit set on L gives viol_valid=1 in the next cycle, with viol_thr=U and viol_sub set to that sub-thread. A store to a different line gives no report.
- R3: Loads never report a violation. A store never reports a violation for load bits held by its own thread or by logically earlier threads.
- R4: When several contexts qualify, the report names the lowest-numbered later thread and, within it, the lowest sub-thread index.
- R5: A checkpoint advances the named thread's current sub-thread by one and saturates at NUM_SUB-1. Accesses are tagged with the sub-thread that was current before any checkpoint in the same cycle.
- R6: A rollback of thread X to sub-thread s clears the load and store bits of X's sub-threads s and above in every line within one cycle. It keeps X's lower sub-threads and sets X's current sub-thread to s.
- R7: A commit of thread X clears all of X's bits in every line and resets X's current sub-thread to 0. Stores from other threads no longer see X's versions.
- R8: A store from T to a line on which another thread's store bit is set gives repl_hit=1 in the next cycle. The store bits of T itself never cause it.
- R9: An access whose own thread is rolled back or committed in the same cycle is dropped: it sets no bit and reports nothing. An access from another thread in that cycle is kept, and it is judged against the tags as they stand after that cycle's clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Speculative access this cycle |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_thr | input | TW | Thread issuing the access |
| acc_line | input | LW | Tracked line index |
| ckpt_valid | input | 1 | Start the next sub-thread |
| ckpt_thr | input | TW | Thread taking the checkpoint |
| rb_valid | input | 1 | Roll back a thread |
| rb_thr | input | TW | Thread rolled back |
| rb_sub | input | SW | First sub-thread cleared |
| cmt_valid | input | 1 | Commit a thread |
| cmt_thr | input | TW | Thread committed |
| viol_valid | output | 1 | Violation found by the previous cycle's store |
| viol_thr | output | TW | Violated thread |
| viol_sub | output | SW | Earliest violated sub-thread |
| repl_hit | output | 1 | Previous store needs its own line version |

## Verification
The function most prone to a same-cycle collision is the eager conflict check against a clear caused by a rollback or commit. The bench drives a rollback of the reading thread together with a store from an earlier thread to the line it read. It expects no report, and then shows through a replicate flag on a later store that the earlier thread's store was still recorded. It also applies a commit together with a load from the committing thread, and then checks with a store from an earlier thread that the load left no trace.

// File: rtl/svt_pkg.sv
package svt_pkg;
   // update applied to one thread's current sub-thread index
   typedef enum logic [1:0] {
      SUB_HOLD   = 2'd0,
      SUB_ADV    = 2'd1,
      SUB_REWIND = 2'd2,
      SUB_RESET  = 2'd3
   } sub_op_e;
endpackage

// File: rtl/svt_sub_ctx.sv
module svt_sub_ctx
   import svt_pkg::*;
#(
   parameter int unsigned NUM_SUB = 2,
   parameter int unsigned SW      = 1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  sub_op_e       op,
   input  logic [SW-1:0] rew_sub,
   output logic [SW-1:0] cur
);
   localparam logic [SW-1:0] LAST = SW'(NUM_SUB - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur <= '0;
      end else begin
         unique case (op)
            SUB_ADV:    if (cur != LAST) cur <= cur + 1'b1;
            SUB_REWIND: cur <= rew_sub;
            SUB_RESET:  cur <= '0;
            default:    cur <= cur;
         endcase
      end
   end
endmodule

// File: rtl/svt_line_tags.sv
module svt_line_tags #(
   parameter int unsigned CTX = 8
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic [CTX-1:0] clr,
   input  logic [CTX-1:0] set_ld,
   input  logic [CTX-1:0] set_st,
   output logic [CTX-1:0] ld_q,
   output logic [CTX-1:0] st_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ld_q <= '0;
         st_q <= '0;
      end else begin
         ld_q <= (ld_q & ~clr) | set_ld;
         st_q <= (st_q & ~clr) | set_st;
      end
   end
endmodule

// File: rtl/svt_viol_pick.sv
module svt_viol_pick #(
   parameter int unsigned NUM_THR = 4,
   parameter int unsigned NUM_SUB = 2,
   parameter int unsigned TW      = 2,
   parameter int unsigned SW      = 1,
   localparam int unsigned CTX    = NUM_THR * NUM_SUB
)(
   input  logic [CTX-1:0] ld_eff,
   input  logic [TW-1:0]  src_thr,
   output logic           hit,
   output logic [TW-1:0]  thr,
   output logic [SW-1:0]  sub
);
   // walk from the top so the lowest qualifying context is left standing
   always_comb begin
      hit = 1'b0;
      thr = '0;
      sub = '0;
      for (int i = int'(CTX) - 1; i >= 0; i--) begin
         if (ld_eff[i] && (i / int'(NUM_SUB)) > int'(src_thr)) begin
            hit = 1'b1;
            thr = TW'(i / int'(NUM_SUB));
            sub = SW'(i % int'(NUM_SUB));
         end
      end
   end
endmodule

// File: rtl/spec_viol_tracker.sv
module spec_viol_tracker
   import svt_pkg::*;
#(
   parameter int unsigned NUM_THR   = 4,
   parameter int unsigned NUM_SUB   = 2,
   parameter int unsigned NUM_LINES = 16,
   localparam int unsigned TW  = (NUM_THR > 1) ? $clog2(NUM_THR) : 1,
   localparam int unsigned SW  = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1,
   localparam int unsigned LW  = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
   localparam int unsigned CTX = NUM_THR * NUM_SUB
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          acc_valid,
   input  logic          acc_store,
   input  logic [TW-1:0] acc_thr,
   input  logic [LW-1:0] acc_line,
   input  logic          ckpt_valid,
   input  logic [TW-1:0] ckpt_thr,
   input  logic          rb_valid,
   input  logic [TW-1:0] rb_thr,
   input  logic [SW-1:0] rb_sub,
   input  logic          cmt_valid,
   input  logic [TW-1:0] cmt_thr,
   output logic          viol_valid,
   output logic [TW-1:0] viol_thr,
   output logic [SW-1:0] viol_sub,
   output logic          repl_hit
);
   // elaboration-time parameter checks
   if (NUM_THR < 2 || (1 << TW) != NUM_THR) begin : g_bad_thr
      $error("NUM_THR must be a power of two, at least 2");
   end
   if (NUM_SUB < 1 || (NUM_SUB > 1 && (1 << SW) != NUM_SUB)) begin : g_bad_sub
      $error("NUM_SUB must be 1 or a power of two");
   end
   if (NUM_LINES < 2 || (1 << LW) != NUM_LINES) begin : g_bad_lines
      $error("NUM_LINES must be a power of two, at least 2");
   end

   logic [SW-1:0]  cur_sub [NUM_THR];
   logic [CTX-1:0] clr, acc_oh, own;
   logic [CTX-1:0] ld_q [NUM_LINES];
   logic [CTX-1:0] st_q [NUM_LINES];
   logic [SW-1:0]  cur_sel;
   logic           kill, acc_ok;

   assign cur_sel = cur_sub[acc_thr];
   assign kill    = (cmt_valid && cmt_thr == acc_thr) || (rb_valid && rb_thr == acc_thr);
   assign acc_ok  = acc_valid && !kill;

   // per-thread sub-thread index; commit outranks rollback outranks checkpoint
   for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
      sub_op_e op;
      always_comb begin
         if (cmt_valid && cmt_thr == TW'(t))       op = SUB_RESET;
         else if (rb_valid && rb_thr == TW'(t))    op = SUB_REWIND;
         else if (ckpt_valid && ckpt_thr == TW'(t)) op = SUB_ADV;
         else                                       op = SUB_HOLD;
      end
      svt_sub_ctx #(.NUM_SUB(NUM_SUB), .SW(SW)) u_ctx (
         .clk     (clk),
         .rst_n   (rst_n),
         .op      (op),
         .rew_sub (rb_sub),
         .cur     (cur_sub[t])
      );
   end

   // per-context clear, access and ownership vectors
   for (genvar c = 0; c < CTX; c++) begin : g_ctx
      localparam int unsigned CT = c / NUM_SUB;
      localparam int unsigned CS = c % NUM_SUB;
      assign clr[c] = (cmt_valid && cmt_thr == TW'(CT)) ||
                      (rb_valid && rb_thr == TW'(CT) && SW'(CS) >= rb_sub);
      assign own[c]    = (acc_thr == TW'(CT));
      assign acc_oh[c] = own[c] && (cur_sel == SW'(CS));
   end

   for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      logic hit_line;
      assign hit_line = acc_ok && (acc_line == LW'(l));
      svt_line_tags #(.CTX(CTX)) u_tags (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (clr),
         .set_ld ((hit_line && !acc_store) ? acc_oh : '0),
         .set_st ((hit_line &&  acc_store) ? acc_oh : '0),
         .ld_q   (ld_q[l]),
         .st_q   (st_q[l])
      );
   end

   // the access is judged against tags after this cycle's clear
   logic [CTX-1:0] sel_ld, sel_st;
   logic           pk_hit;
   logic [TW-1:0]  pk_thr;
   logic [SW-1:0]  pk_sub;

   assign sel_ld = ld_q[acc_line] & ~clr;
   assign sel_st = st_q[acc_line] & ~clr;

   svt_viol_pick #(.NUM_THR(NUM_THR), .NUM_SUB(NUM_SUB), .TW(TW), .SW(SW)) u_pick (
      .ld_eff  (sel_ld),
      .src_thr (acc_thr),
      .hit     (pk_hit),
      .thr     (pk_thr),
      .sub     (pk_sub)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         viol_valid <= 1'b0;
         viol_thr   <= '0;
         viol_sub   <= '0;
         repl_hit   <= 1'b0;
      end else begin
         viol_valid <= acc_ok && acc_store && pk_hit;
         viol_thr   <= pk_thr;
         viol_sub   <= pk_sub;
         repl_hit   <= acc_ok && acc_store && |(sel_st & ~own);
      end
   end
endmodule

module spec_viol_tracker_chk #(
   parameter int unsigned TW = 2,
   parameter int unsigned SW = 1
)(
   input logic          clk,
   input logic          rst_n,
   input logic          acc_valid,
   input logic          acc_store,
   input logic [TW-1:0] acc_thr,
   input logic          rb_valid,
   input logic [TW-1:0] rb_thr,
   input logic [SW-1:0] rb_sub,
   input logic          cmt_valid,
   input logic [TW-1:0] cmt_thr,
   input logic          viol_valid,
   input logic [TW-1:0] viol_thr,
   input logic [SW-1:0] viol_sub,
   input logic          repl_hit
);
   // R1
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!viol_valid && !repl_hit));

   // R2
   viol_from_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      viol_valid |-> $past(acc_valid && acc_store));

   // R3
   viol_later_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      viol_valid |-> (viol_thr > $past(acc_thr)));

   // R8
   repl_from_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      repl_hit |-> $past(acc_valid && acc_store));

   // R6
   rb_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_valid && $past(rb_valid) && viol_thr == $past(rb_thr)) |-> (viol_sub < $past(rb_sub)));

   // R9
   killed_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(acc_valid && ((cmt_valid && cmt_thr == acc_thr) || (rb_valid && rb_thr == acc_thr)))
      |-> (!viol_valid && !repl_hit));
endmodule

bind spec_viol_tracker spec_viol_tracker_chk #(.TW(TW), .SW(SW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .acc_valid  (acc_valid),
   .acc_store  (acc_store),
   .acc_thr    (acc_thr),
   .rb_valid   (rb_valid),
   .rb_thr     (rb_thr),
   .rb_sub     (rb_sub),
   .cmt_valid  (cmt_valid),
   .cmt_thr    (cmt_thr),
   .viol_valid (viol_valid),
   .viol_thr   (viol_thr),
   .viol_sub   (viol_sub),
   .repl_hit   (repl_hit)
);

// File: tb/spec_viol_tracker_bench.sv
module spec_viol_tracker_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_valid = 1'b0, acc_store = 1'b0;
   logic [1:0] acc_thr = '0;
   logic [3:0] acc_line = '0;
   logic       ckpt_valid = 1'b0;
   logic [1:0] ckpt_thr = '0;
   logic       rb_valid = 1'b0;
   logic [1:0] rb_thr = '0;
   logic       rb_sub = 1'b0;
   logic       cmt_valid = 1'b0;
   logic [1:0] cmt_thr = '0;
   logic       viol_valid, repl_hit;
   logic [1:0] viol_thr;
   logic       viol_sub;

   int total = 0;
   int bad = 0;
   bit stim_done = 1'b0;

   typedef struct {
      logic       v;
      logic [1:0] t;
      logic       s;
      logic       r;
      string      tag;
   } exp_t;
   exp_t sb_q[$];

   always #5 clk = ~clk;

   spec_viol_tracker u_spec_viol_tracker (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_store(acc_store), .acc_thr(acc_thr), .acc_line(acc_line),
      .ckpt_valid(ckpt_valid), .ckpt_thr(ckpt_thr),
      .rb_valid(rb_valid), .rb_thr(rb_thr), .rb_sub(rb_sub),
      .cmt_valid(cmt_valid), .cmt_thr(cmt_thr),
      .viol_valid(viol_valid), .viol_thr(viol_thr), .viol_sub(viol_sub), .repl_hit(repl_hit)
   );

   // driver: one call = one cycle of stimulus plus its expected result
   task automatic drive(input logic av, input logic ast, input logic [1:0] at, input logic [3:0] al,
                        input logic ckv, input logic [1:0] ckt,
                        input logic rbv, input logic [1:0] rbt, input logic rbs,
                        input logic cmv, input logic [1:0] cmt,
                        input logic ev, input logic [1:0] et, input logic es, input logic er,
                        input string tag);
      exp_t e;
      @(negedge clk);
      acc_valid = av; acc_store = ast; acc_thr = at; acc_line = al;
      ckpt_valid = ckv; ckpt_thr = ckt;
      rb_valid = rbv; rb_thr = rbt; rb_sub = rbs;
      cmt_valid = cmv; cmt_thr = cmt;
      e.v = ev; e.t = et; e.s = es; e.r = er; e.tag = tag;
      sb_q.push_back(e);
   endtask

   task automatic acc(input logic st, input logic [1:0] t, input logic [3:0] l,
                      input logic ev, input logic [1:0] et, input logic es, input logic er,
                      input string tag);
      drive(1'b1, st, t, l, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, ev, et, es, er, tag);
   endtask

   task automatic ckpt(input logic [1:0] t, input string tag);
      drive(1'b0, 1'b0, 2'd0, 4'd0, 1'b1, t, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, tag);
   endtask

   task automatic rollback(input logic [1:0] t, input logic s, input string tag);
      drive(1'b0, 1'b0, 2'd0, 4'd0, 1'b0, 2'd0, 1'b1, t, s, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, tag);
   endtask

   task automatic commit(input logic [1:0] t, input string tag);
      drive(1'b0, 1'b0, 2'd0, 4'd0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1, t, 1'b0, 2'd0, 1'b0, 1'b0, tag);
   endtask

   // monitor: compares each registered result after the edge that made it
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb_q.size() != 0) begin
            exp_t e;
            e = sb_q.pop_front();
            total++;
            if (viol_valid !== e.v || repl_hit !== e.r ||
                (e.v && (viol_thr !== e.t || viol_sub !== e.s))) begin
               bad++;
               $display("FAIL %s: got v=%0b thr=%0d sub=%0d repl=%0b, expected v=%0b thr=%0d sub=%0d repl=%0b",
                        e.tag, viol_valid, viol_thr, viol_sub, repl_hit, e.v, e.t, e.s, e.r);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!stim_done) begin
         bad++;
         total++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      total++;
      if (viol_valid !== 1'b0 || repl_hit !== 1'b0) begin
         bad++;
         $display("FAIL R1 reset: got v=%0b repl=%0b, expected v=0 repl=0", viol_valid, repl_hit);
      end
      rst_n = 1'b1;
      drive(1'b0, 1'b0, 2'd0, 4'd0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, "R1 idle");
      // encodings: lower thread ID is earlier; store=1, load=0
      acc(1'b0, 2'd2, 4'd3, 1'b0, 2'd0, 1'b0, 1'b0, "R3 load never violates");
      acc(1'b1, 2'd3, 4'd3, 1'b0, 2'd0, 1'b0, 1'b0, "R3 later-thread store");
      acc(1'b1, 2'd1, 4'd4, 1'b0, 2'd0, 1'b0, 1'b0, "R2 other line");
      acc(1'b1, 2'd1, 4'd3, 1'b1, 2'd2, 1'b0, 1'b1, "R2 earlier store hits read line");
      ckpt(2'd2, "R5 checkpoint");
      acc(1'b0, 2'd2, 4'd5, 1'b0, 2'd0, 1'b0, 1'b0, "R5 load in sub1");
      acc(1'b0, 2'd3, 4'd5, 1'b0, 2'd0, 1'b0, 1'b0, "R4 load by thread 3");
      acc(1'b1, 2'd0, 4'd5, 1'b1, 2'd2, 1'b1, 1'b0, "R4 lowest later thread wins");
      ckpt(2'd2, "R5 saturating checkpoint");
      acc(1'b0, 2'd2, 4'd6, 1'b0, 2'd0, 1'b0, 1'b0, "R5 load after saturation");
      acc(1'b1, 2'd1, 4'd6, 1'b1, 2'd2, 1'b1, 1'b0, "R5 saturated at sub1");
      rollback(2'd2, 1'b1, "R6 rollback to sub1");
      acc(1'b1, 2'd0, 4'd5, 1'b1, 2'd3, 1'b0, 1'b0, "R6 sub1 bits cleared");
      acc(1'b1, 2'd1, 4'd3, 1'b1, 2'd2, 1'b0, 1'b1, "R6 sub0 bits kept");
      acc(1'b0, 2'd2, 4'd11, 1'b0, 2'd0, 1'b0, 1'b0, "R6 load after rollback");
      acc(1'b1, 2'd0, 4'd11, 1'b1, 2'd2, 1'b1, 1'b0, "R6 current sub set to rb_sub");
      commit(2'd3, "R7 commit");
      acc(1'b1, 2'd1, 4'd3, 1'b1, 2'd2, 1'b0, 1'b0, "R7 committed version gone");
      acc(1'b1, 2'd0, 4'd5, 1'b0, 2'd0, 1'b0, 1'b0, "R7 committed loads gone");
      acc(1'b0, 2'd3, 4'd7, 1'b0, 2'd0, 1'b0, 1'b0, "R9 setup load");
      drive(1'b1, 1'b1, 2'd1, 4'd7, 1'b0, 2'd0, 1'b1, 2'd3, 1'b0, 1'b0, 2'd0,
            1'b0, 2'd0, 1'b0, 1'b0, "R9 store sees same-cycle rollback");
      acc(1'b1, 2'd0, 4'd7, 1'b0, 2'd0, 1'b0, 1'b1, "R9 other-thread store kept");
      drive(1'b1, 1'b0, 2'd2, 4'd8, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 2'd2,
            1'b0, 2'd0, 1'b0, 1'b0, "R9 access dropped on commit");
      acc(1'b1, 2'd0, 4'd8, 1'b0, 2'd0, 1'b0, 1'b0, "R9 dropped load left no bit");
      acc(1'b1, 2'd2, 4'd9, 1'b0, 2'd0, 1'b0, 1'b0, "R8 first version");
      acc(1'b1, 2'd1, 4'd9, 1'b0, 2'd0, 1'b0, 1'b1, "R8 second thread needs copy");
      acc(1'b1, 2'd1, 4'd10, 1'b0, 2'd0, 1'b0, 1'b0, "R8 fresh line");
      acc(1'b1, 2'd1, 4'd10, 1'b0, 2'd0, 1'b0, 1'b0, "R8 own version only");
      drive(1'b1, 1'b0, 2'd1, 4'd12, 1'b1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0,
            1'b0, 2'd0, 1'b0, 1'b0, "R5 load with same-cycle checkpoint");
      acc(1'b1, 2'd0, 4'd12, 1'b1, 2'd1, 1'b0, 1'b0, "R5 load tagged with old sub");
      acc(1'b0, 2'd1, 4'd12, 1'b0, 2'd0, 1'b0, 1'b0, "R5 load in new sub");
      acc(1'b1, 2'd0, 4'd12, 1'b1, 2'd1, 1'b0, 1'b0, "R4 lowest sub wins");
      rollback(2'd1, 1'b0, "R6 rollback whole thread");
      acc(1'b1, 2'd0, 4'd12, 1'b0, 2'd0, 1'b0, 1'b0, "R6 all subs cleared");
      drive(1'b0, 1'b0, 2'd0, 4'd0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, "R1 idle end");
      while (sb_q.size() != 0) @(posedge clk);
      repeat (2) @(posedge clk);
      stim_done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule